// File: doc/BRIEF.md
# SPI Serial Clock Prescaler

This block derives the serial clock of an SPI master from the main clock. It does this in two cascaded stages. A coarse pre-divider, selected by a 2-bit field, produces an enable tick every 2, 4, 8 or 16 main-clock cycles. A baud counter, set by a 6-bit field, counts those ticks and toggles the serial clock after every (BRG+1) ticks, so the full serial period is 2*(BRG+1) ticks.

Besides the serial clock, which rests at a selectable idle level, the block drives two single-cycle strobes. One marks the leading edge of each serial-clock period and the other marks the trailing edge. A shift engine uses these strobes to launch and capture bits without having to detect edges on the serial clock. Software works out the divider fields for a requested frequency and places them on the inputs before it enables the block.

Top module: `spi_clk_prescaler`

## Requirements
- R1: While enabled, every serial-clock half-period lasts exactly (2 << DIV) * (BRG+1) main-clock cycles.
- R2: DIV=0 with BRG=4 gives a full serial period of 20 main-clock cycles. DIV=3 with BRG=63 gives a full period of 2048 main-clock cycles.
- R3: A BRG value below 4 behaves exactly as BRG=4.
- R4: While the block is disabled, the serial clock equals the polarity input (0 means idle low, 1 means idle high), and neither strobe is asserted.
- R5: The counters restart from zero on enable. The first serial-clock transition appears after a full half-period, counting the first rising clock edge that samples enable high as cycle 1.
- R6: The leading-edge strobe is high for exactly one cycle: the cycle in which the serial clock first shows the non-idle level. The trailing-edge strobe is high for exactly one cycle: the cycle in which the serial clock returns to the idle level. At all other times both strobes are low.
- R7: DIV and BRG are captured only while the block is disabled. Changing them while it is enabled has no effect on the half-period until the next enable.
- R8: Synchronous reset clears the counters and loads BRG=4 and DIV=0. If enable is already high when reset releases, the block runs at the fastest rate, whatever the field inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable; counters are held at zero while this is low |
| div_sel | input | 2 | Pre-divider select; ratio is 2 << div_sel |
| brg_sel | input | 6 | Baud divider value; legal range 4 to 63 |
| cpol | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Serial clock |
| lead_pulse | output | 1 | One-cycle strobe at each leading edge |
| trail_pulse | output | 1 | One-cycle strobe at each trailing edge |

## Verification
The case hardest to reach from the ports is the one where the configuration is never loaded at all: enable is already high when reset releases, so the block has to run from its reset defaults. The stimulus holds enable high through reset with the slowest field values applied. It then checks that the half-period is the fastest one. Field changes made while the block is enabled are also exercised. The stimulus alters both fields after the first transition of each run and checks that the later half-periods keep the length set by the captured values. The bench sweeps every DIV value and a set of BRG values that includes the clamped, minimum and maximum settings. It uses both polarities and measures four half-periods per setting.

// File: rtl/spi_presc_pkg.sv
package spi_presc_pkg;

    parameter int DIV_W   = 2;
    parameter int BRG_W   = 6;
    parameter int BRG_MIN = 4;
    // pre-divider counter must count up to (2 << max DIV) - 1
    parameter int PRE_W   = 1 << DIV_W;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [BRG_W-1:0] brg;
    } presc_cfg_t;

    localparam presc_cfg_t CFG_RESET = '{div: '0, brg: BRG_W'(BRG_MIN)};

    // terminal count of the pre-divider: (2 << d) - 1
    function automatic logic [PRE_W-1:0] pre_last(input logic [DIV_W-1:0] d);
        logic [PRE_W:0] span;
        logic [PRE_W:0] lastv;
        span  = (PRE_W+1)'(2) << d;
        lastv = span - (PRE_W+1)'(1);
        return lastv[PRE_W-1:0];
    endfunction

    function automatic logic [BRG_W-1:0] brg_floor(input logic [BRG_W-1:0] b);
        return (b < BRG_W'(BRG_MIN)) ? BRG_W'(BRG_MIN) : b;
    endfunction

endpackage

// File: rtl/spi_presc_cfg.sv
module spi_presc_cfg
    import spi_presc_pkg::*;
#(
    parameter int CFG_DIV_W = DIV_W,
    parameter int CFG_BRG_W = BRG_W,
    parameter int CFG_MIN   = BRG_MIN
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [CFG_DIV_W-1:0] div_in,
    input  logic [CFG_BRG_W-1:0] brg_in,
    output presc_cfg_t           cfg_o
);

    logic [CFG_BRG_W-1:0] brg_eff;

    generate
        if (CFG_MIN > 0) begin : g_clamp
            assign brg_eff = brg_floor(brg_in);
        end else begin : g_pass
            assign brg_eff = brg_in;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_o <= CFG_RESET;
        end else if (!en) begin
            cfg_o.div <= div_in;
            cfg_o.brg <= brg_eff;
        end
    end

    // R3
    brg_floor_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_o.brg >= CFG_BRG_W'(CFG_MIN));

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$past(rst)) |-> $stable(cfg_o));

endmodule

// File: rtl/spi_presc_pre.sv
module spi_presc_pre
    import spi_presc_pkg::*;
#(
    parameter int PRE_DIV_W = DIV_W,
    parameter int PRE_CNT_W = PRE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [PRE_DIV_W-1:0] div,
    output logic                 tick_o
);

    logic [PRE_CNT_W-1:0] cnt_q;
    logic [PRE_CNT_W-1:0] last;
    logic                 at_last;

    assign last    = pre_last(div);
    assign at_last = (cnt_q == last);
    assign tick_o  = en && at_last;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
        end else if (at_last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PRE_CNT_W'(1);
        end
    end

    // R5
    pre_restart_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt_q == '0));

    // R1
    pre_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= last);

endmodule

// File: rtl/spi_presc_baud.sv
module spi_presc_baud
    import spi_presc_pkg::*;
#(
    parameter int BD_W = BRG_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            tick,
    input  logic [BD_W-1:0] brg,
    output logic            phase_o,
    output logic            lead_o,
    output logic            trail_o
);

    typedef enum logic {PH_IDLE = 1'b0, PH_ACTIVE = 1'b1} phase_e;

    phase_e          phase_q;
    logic [BD_W-1:0] bcnt_q;
    logic            flip;

    assign flip    = tick && (bcnt_q == brg);
    assign phase_o = (phase_q == PH_ACTIVE);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            bcnt_q  <= '0;
            phase_q <= PH_IDLE;
            lead_o  <= 1'b0;
            trail_o <= 1'b0;
        end else begin
            lead_o  <= flip && (phase_q == PH_IDLE);
            trail_o <= flip && (phase_q == PH_ACTIVE);
            if (tick) begin
                if (flip) begin
                    bcnt_q  <= '0;
                    phase_q <= (phase_q == PH_IDLE) ? PH_ACTIVE : PH_IDLE;
                end else begin
                    bcnt_q <= bcnt_q + BD_W'(1);
                end
            end
        end
    end

    // R4
    off_state_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!phase_o && !lead_o && !trail_o));

    // R6
    lead_level_chk: assert property (@(posedge clk) disable iff (rst)
        lead_o |-> phase_o);

    // R6
    trail_level_chk: assert property (@(posedge clk) disable iff (rst)
        trail_o |-> !phase_o);

    // R6
    lead_width_chk: assert property (@(posedge clk) disable iff (rst)
        lead_o |=> !lead_o);

    // R6
    trail_width_chk: assert property (@(posedge clk) disable iff (rst)
        trail_o |=> !trail_o);

endmodule

// File: rtl/spi_clk_prescaler.sv
module spi_clk_prescaler
    import spi_presc_pkg::*;
#(
    parameter int TOP_DIV_W = DIV_W,
    parameter int TOP_BRG_W = BRG_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [TOP_DIV_W-1:0] div_sel,
    input  logic [TOP_BRG_W-1:0] brg_sel,
    input  logic                 cpol,
    output logic                 sclk,
    output logic                 lead_pulse,
    output logic                 trail_pulse
);

    localparam int CNT_W = 1 << TOP_DIV_W;

    presc_cfg_t cfg;
    logic       tick;
    logic       phase;

    spi_presc_cfg #(
        .CFG_DIV_W (TOP_DIV_W),
        .CFG_BRG_W (TOP_BRG_W),
        .CFG_MIN   (BRG_MIN)
    ) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .div_in (div_sel),
        .brg_in (brg_sel),
        .cfg_o  (cfg)
    );

    spi_presc_pre #(
        .PRE_DIV_W (TOP_DIV_W),
        .PRE_CNT_W (CNT_W)
    ) u_pre (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .div    (cfg.div),
        .tick_o (tick)
    );

    spi_presc_baud #(
        .BD_W (TOP_BRG_W)
    ) u_baud (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .tick    (tick),
        .brg     (cfg.brg),
        .phase_o (phase),
        .lead_o  (lead_pulse),
        .trail_o (trail_pulse)
    );

    assign sclk = phase ^ cpol;

    // R6
    edge_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(lead_pulse && trail_pulse));

    // R6
    sclk_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!lead_pulse && !trail_pulse && $stable(cpol) && !$past(rst)) |-> $stable(sclk));

endmodule

// File: tb/spi_clk_prescaler_tb.sv
module spi_clk_prescaler_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic [1:0] div_sel = 2'd0;
    logic [5:0] brg_sel = 6'd4;
    logic       cpol = 1'b0;
    logic       sclk;
    logic       lead_pulse;
    logic       trail_pulse;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    spi_clk_prescaler u_dut (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .div_sel     (div_sel),
        .brg_sel     (brg_sel),
        .cpol        (cpol),
        .sclk        (sclk),
        .lead_pulse  (lead_pulse),
        .trail_pulse (trail_pulse)
    );

    function automatic int exp_half(input int d, input int b);
        int bb;
        bb = (b < 4) ? 4 : b;
        return (2 << d) * (bb + 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // measure one half-period; returns cycle count, flags misaligned strobes
    task automatic measure(input bit pol, output int cycles, output bit pulse_ok);
        logic prev;
        prev = sclk;
        cycles = 0;
        pulse_ok = 1'b1;
        for (int i = 0; i < 5000; i++) begin
            @(posedge clk);
            @(negedge clk);
            cycles++;
            if (sclk != prev) begin
                if (lead_pulse !== (sclk != pol)) pulse_ok = 1'b0;
                if (trail_pulse !== (sclk == pol)) pulse_ok = 1'b0;
                break;
            end else if (lead_pulse || trail_pulse) begin
                pulse_ok = 1'b0;
            end
        end
    endtask

    task automatic run_cfg(input int d, input int b, input bit pol, input string req);
        int h;
        int cyc;
        bit pok;
        h = exp_half(d, b);
        @(negedge clk);
        en = 1'b0;
        div_sel = 2'(d);
        brg_sel = 6'(b);
        cpol = pol;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        // R4 idle level while disabled
        check(sclk == pol && !lead_pulse && !trail_pulse, "R4", int'(sclk), int'(pol));
        en = 1'b1;
        for (int k = 0; k < 4; k++) begin
            measure(pol, cyc, pok);
            if (k == 0)
                check(cyc == h, "R5", cyc, h);
            else if (k >= 2)
                check(cyc == h, "R7", cyc, h);
            else
                check(cyc == h, req, cyc, h);
            check(pok, "R6", int'(pok), 1);
            if (k == 0) begin
                div_sel = ~div_sel;
                brg_sel = brg_sel ^ 6'h2A;
            end
        end
        en = 1'b0;
    endtask

    initial begin
        int cyc;
        bit pok;
        // R8: enable high through reset, slow fields on the inputs
        en = 1'b1;
        div_sel = 2'd3;
        brg_sel = 6'd63;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(sclk == 1'b0 && !lead_pulse && !trail_pulse, "R8", int'(sclk), 0);
        rst = 1'b0;
        measure(1'b0, cyc, pok);
        check(cyc == 10, "R8", cyc, 10);
        measure(1'b0, cyc, pok);
        check(cyc == 10, "R8", cyc, 10);
        check(pok, "R6", int'(pok), 1);

        // R2 extremes
        run_cfg(0, 4, 1'b0, "R2");
        run_cfg(3, 63, 1'b1, "R2");

        // R1 / R3 sweep
        for (int d = 0; d < 4; d++) begin
            int blist[6] = '{0, 3, 4, 5, 9, 63};
            for (int j = 0; j < 6; j++) begin
                run_cfg(d, blist[j], 1'((d + j) % 2), (blist[j] < 4) ? "R3" : "R1");
            end
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule